// File: doc/BRIEF.md
# Byte-Order Swap Unit

This unit carries out the byte-order conversion step of an extended packet-filter style processor. It takes a 64-bit destination register value and returns it in the requested byte order. The width of the conversion, 16, 32 or 64 bits, is chosen by the immediate field. An instruction-class flag picks between the narrow arithmetic class and the wide arithmetic class.

In the narrow class, a single order bit names the target order. A clear bit means little endian. A set bit means big endian; it is the bit worth 0x08 in the opcode. Each conversion is taken relative to the host order, which is fixed at build time. In the wide class, the order bit is reserved and the bytes are always reversed. Only the destination value is an operand. No source register or immediate data value takes part.

Requests enter through a valid/ready stream and leave through one. A request is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. Its result is held in a single output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its value and no new request is taken.

Top module: `byte_order_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released with no request accepted, `out_valid` is 0.
- R2: Narrow class (`in_wide_class`=0), order bit 0 (little endian), little-endian host: the low bytes of the selected width pass through in their original order.
- R3: Narrow class with order bit 1 (big endian) on a little-endian host: the bytes of the selected width are reversed.
- R4: Wide class (`in_wide_class`=1) with order bit 0: the bytes of the selected width are always reversed.
- R5: A legal result is zero above the selected width. A 16-bit conversion clears bits 63:16, and a 32-bit conversion clears bits 63:32.
- R6: An immediate other than 16, 32 or 64 sets `out_illegal` and returns the operand unchanged.
- R7: Wide class with order bit 1 sets `out_illegal` and returns the operand unchanged.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_data` and `out_illegal` hold their values.
- R9: A request accepted at one rising edge appears on `out_valid`/`out_data` right after that edge, with one cycle of latency. If the output is drained with no new request, `out_valid` drops.
- R10: With `HOST_BIG_ENDIAN`=1, the narrow-class order bit works the other way round. Order bit 1 keeps the byte order and order bit 0 reverses it. The wide class still always reverses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_data | input | 64 | Destination register value |
| in_wide_class | input | 1 | 1 = wide (64-bit) arithmetic class, 0 = narrow class |
| in_order_be | input | 1 | Order bit: 1 = big-endian target (narrow), reserved (wide) |
| in_width_sel | input | IMM_W | Immediate selecting conversion width |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Converted value |
| out_illegal | output | 1 | Encoding was illegal; `out_data` equals the operand |

## Verification
The bench builds two copies side by side. One uses a little-endian host and the other uses `HOST_BIG_ENDIAN`=1. Both receive the same stimulus. With both copies present, the identity and reversal paths of the narrow class are each exercised in both directions, and the two hosts must agree on every wide-class and illegal case. `IMM_W` stays at 32. This lets the bench reach immediates far beyond 64, plus odd values such as 8, 17 and 48.

// File: rtl/bou_pkg.sv
package bou_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_SIZES = 3;

  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_BAD = 2'd3
  } swap_size_e;

  typedef struct packed {
    logic              illegal;
    logic [WORD_W-1:0] value;
  } swap_res_t;
endpackage

// File: rtl/bou_decode.sv
module bou_decode
  import bou_pkg::*;
#(
  parameter bit          HOST_BIG = 1'b0,
  parameter int unsigned IMM_W    = 32
) (
  input  logic             wide_class,
  input  logic             order_be,
  input  logic [IMM_W-1:0] width_sel,
  output swap_size_e       size,
  output logic             reverse,
  output logic             illegal
);
  always_comb begin
    if (width_sel == IMM_W'(16))      size = SZ_16;
    else if (width_sel == IMM_W'(32)) size = SZ_32;
    else if (width_sel == IMM_W'(64)) size = SZ_64;
    else                              size = SZ_BAD;
  end

  // The wide class reserves the order bit and always reverses.
  assign illegal = (size == SZ_BAD) | (wide_class & order_be);
  assign reverse = wide_class | (order_be ^ HOST_BIG);
endmodule

// File: rtl/bou_lanes.sv
module bou_lanes
  import bou_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  input  swap_size_e        size,
  input  logic              reverse,
  input  logic              illegal,
  output logic [WORD_W-1:0] dout
);
  logic [N_SIZES-1:0][WORD_W-1:0] swapped;
  logic [N_SIZES-1:0][WORD_W-1:0] kept;

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int unsigned NB   = 2 << g;
    localparam int unsigned NBIT = NB * BYTE_W;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign swapped[g][b*BYTE_W +: BYTE_W] = din[(NB-1-b)*BYTE_W +: BYTE_W];
    end
    if (NBIT < WORD_W) begin : g_zext
      assign swapped[g][WORD_W-1:NBIT] = '0;
      assign kept[g] = {{(WORD_W-NBIT){1'b0}}, din[NBIT-1:0]};
    end else begin : g_full
      assign kept[g] = din;
    end
  end

  always_comb begin
    dout = din;
    if (!illegal) begin
      case (size)
        SZ_16:   dout = reverse ? swapped[0] : kept[0];
        SZ_32:   dout = reverse ? swapped[1] : kept[1];
        SZ_64:   dout = reverse ? swapped[2] : kept[2];
        default: dout = din;
      endcase
    end
  end
endmodule

// File: rtl/bou_out_stage.sv
module bou_out_stage #(
  parameter int unsigned W = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);
  logic         held_q;
  logic [W-1:0] data_q;

  assign in_ready    = !held_q || out_ready;
  assign out_valid   = held_q;
  assign out_payload = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      held_q <= 1'b1;
      data_q <= in_payload;
    end else if (out_ready) begin
      held_q <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_order_unit.sv
module byte_order_unit
  import bou_pkg::*;
#(
  parameter bit          HOST_BIG_ENDIAN = 1'b0,
  parameter int unsigned IMM_W           = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      in_data,
  input  logic             in_wide_class,
  input  logic             in_order_be,
  input  logic [IMM_W-1:0] in_width_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [63:0]      out_data,
  output logic             out_illegal
);
  localparam int unsigned RES_W = $bits(swap_res_t);

  swap_size_e        size;
  logic              reverse;
  logic              illegal;
  logic [WORD_W-1:0] conv;
  swap_res_t         res_in;
  swap_res_t         res_out;

  bou_decode #(.HOST_BIG(HOST_BIG_ENDIAN), .IMM_W(IMM_W)) u_decode (
    .wide_class (in_wide_class),
    .order_be   (in_order_be),
    .width_sel  (in_width_sel),
    .size       (size),
    .reverse    (reverse),
    .illegal    (illegal)
  );

  bou_lanes u_lanes (
    .din     (in_data),
    .size    (size),
    .reverse (reverse),
    .illegal (illegal),
    .dout    (conv)
  );

  assign res_in.illegal = illegal;
  assign res_in.value   = conv;

  bou_out_stage #(.W(RES_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_payload  (res_in),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (res_out)
  );

  assign out_data    = res_out.value;
  assign out_illegal = res_out.illegal;
endmodule

// File: rtl/bou_chk.sv
module bou_chk #(
  parameter int unsigned IMM_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [63:0]      in_data,
  input logic             in_wide_class,
  input logic             in_order_be,
  input logic [IMM_W-1:0] in_width_sel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [63:0]      out_data,
  input logic             out_illegal
);
  logic fire, legal_w;
  assign fire    = in_valid && in_ready;
  assign legal_w = (in_width_sel == IMM_W'(16)) || (in_width_sel == IMM_W'(32)) ||
                   (in_width_sel == IMM_W'(64));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_illegal));

  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r6_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !legal_w |=> out_illegal && out_data == $past(in_data));

  a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_wide_class && in_order_be |=> out_illegal && out_data == $past(in_data));

  a_r5_zext16: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_width_sel == IMM_W'(16) && !(in_wide_class && in_order_be)
    |=> !out_illegal && out_data[63:16] == '0);

  a_r5_zext32: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_width_sel == IMM_W'(32) && !(in_wide_class && in_order_be)
    |=> !out_illegal && out_data[63:32] == '0);
endmodule

bind byte_order_unit bou_chk #(.IMM_W(IMM_W)) u_chk (.*);

// File: tb/tb_byte_order_unit.sv
module tb_byte_order_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, wide, obe, out_ready;
  logic [63:0] din;
  logic [31:0] wsel;
  logic [1:0]  iready, ovalid, oill;
  logic [63:0] od0, od1;

  byte_order_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(iready[0]),
    .in_data(din), .in_wide_class(wide), .in_order_be(obe), .in_width_sel(wsel),
    .out_valid(ovalid[0]), .out_ready(out_ready), .out_data(od0), .out_illegal(oill[0]));

  byte_order_unit #(.HOST_BIG_ENDIAN(1'b1)) dut_be (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(iready[1]),
    .in_data(din), .in_wide_class(wide), .in_order_be(obe), .in_width_sel(wsel),
    .out_valid(ovalid[1]), .out_ready(out_ready), .out_data(od1), .out_illegal(oill[1]));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic        ev [2];
  logic [63:0] ed [2];
  logic        ei [2];
  int          ew [2];
  string       et [2];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [64:0] ref_op(logic [63:0] d, logic w, logic be,
                                         logic [31:0] s, logic hb, output int nb);
    logic rev;
    logic [63:0] r;
    if (s == 16) nb = 2; else if (s == 32) nb = 4; else if (s == 64) nb = 8; else nb = 0;
    if (nb == 0 || (w && be)) return {1'b1, d};
    rev = w ? 1'b1 : (be != hb);
    r = '0;
    for (int i = 0; i < nb; i++)
      r[8*i +: 8] = rev ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
    return {1'b0, r};
  endfunction

  task automatic compare_all();
    for (int h = 0; h < 2; h++) begin
      logic [63:0] od;
      od = (h == 0) ? od0 : od1;
      chk("R9 out_valid", 64'(ovalid[h]), 64'(ev[h]));
      chk("R8 in_ready", 64'(iready[h]), 64'(!ev[h] || out_ready));
      if (ev[h]) begin
        chk({et[h], " data"}, od, ed[h]);
        chk({et[h], " illegal"}, 64'(oill[h]), 64'(ei[h]));
        if (!ei[h] && ew[h] < 8) chk("R5 upper zero", od >> (8*ew[h]), 64'd0);
      end
    end
  endtask

  task automatic cycle(logic v, logic [63:0] d, logic w, logic be, logic [31:0] s, logic rdy);
    @(negedge clk);
    compare_all();
    for (int h = 0; h < 2; h++) begin
      logic fire;
      logic [64:0] r;
      int nb;
      fire = v && (!ev[h] || rdy);
      if (fire) begin
        r = ref_op(d, w, be, s, h[0], nb);
        ev[h] = 1'b1; ei[h] = r[64]; ed[h] = r[63:0]; ew[h] = nb;
        if (r[64])      et[h] = (w && be) ? "R7" : "R6";
        else if (h == 1) et[h] = "R10";
        else if (w)      et[h] = "R4";
        else if (be)     et[h] = "R3";
        else             et[h] = "R2";
      end else if (rdy) begin
        ev[h] = 1'b0;
      end else if (ev[h]) begin
        et[h] = "R8 hold";
      end
    end
    in_valid = v; din = d; wide = w; obe = be; wsel = s; out_ready = rdy;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; din = '0; wide = 0; obe = 0; wsel = '0; out_ready = 1;
    for (int h = 0; h < 2; h++) begin ev[h] = 0; ed[h] = '0; ei[h] = 0; ew[h] = 8; et[h] = "R1"; end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(ovalid[0]), 64'd0);
    chk("R1 reset valid be", 64'(ovalid[1]), 64'd0);
    rst_n = 1'b1;
    cycle(0, '0, 0, 0, 16, 1);
    cycle(0, '0, 0, 0, 16, 1); // R1 idle after reset

    // R2/R3/R4/R10 across all widths
    for (int k = 0; k < 3; k++) begin
      logic [31:0] s;
      s = 32'(16 << k);
      cycle(1, 64'h0123_4567_89ab_cdef, 0, 0, s, 1);
      cycle(1, 64'h0123_4567_89ab_cdef, 0, 1, s, 1);
      cycle(1, 64'hfedc_ba98_7654_3210, 1, 0, s, 1);
    end
    // R6 illegal widths, R7 reserved bit
    cycle(1, 64'h1122_3344_5566_7788, 0, 0, 0, 1);
    cycle(1, 64'h1122_3344_5566_7788, 0, 1, 8, 1);
    cycle(1, 64'h1122_3344_5566_7788, 1, 0, 48, 1);
    cycle(1, 64'h1122_3344_5566_7788, 0, 0, 17, 1);
    cycle(1, 64'h1122_3344_5566_7788, 0, 0, 32'h0001_0010, 1);
    cycle(1, 64'haabb_ccdd_eeff_0011, 1, 1, 64, 1);
    cycle(1, 64'haabb_ccdd_eeff_0011, 1, 1, 16, 1);
    // R8 back-pressure: stall several cycles with new requests offered
    cycle(1, 64'h0807_0605_0403_0201, 0, 1, 64, 0);
    cycle(1, 64'hdead_beef_cafe_f00d, 1, 0, 32, 0);
    cycle(1, 64'hdead_beef_cafe_f00d, 1, 0, 32, 0);
    cycle(1, 64'hdead_beef_cafe_f00d, 1, 0, 32, 1);
    cycle(0, '0, 0, 0, 16, 1);
    cycle(0, '0, 0, 0, 16, 1); // R9 drain drops valid

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] s;
      case ($urandom % 7)
        0: s = 16; 1: s = 32; 2, 3: s = 64; 4: s = 8; 5: s = 128;
        default: s = $urandom;
      endcase
      cycle(1'($urandom % 4 != 0), {$urandom, $urandom}, 1'($urandom), 1'($urandom),
            s, 1'($urandom % 3 != 0));
    end
    cycle(0, '0, 0, 0, 16, 1);
    cycle(0, '0, 0, 0, 16, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule